// File: doc/BRIEF.md
# Indexed CRT Controller Host Register File

This block is the processor-facing side of a CRT display controller. A host on an 8-bit I/O bus selects one of twenty-five timing and memory-address registers by writing an index to an address port. It then writes the value through the data port one address above. The stored registers leave the block as one flat bus. A separate display timing generator consumes that bus.

The block also holds a miscellaneous output byte. Bit 0 of that byte moves the port pair between a monochrome base (3B4h/3B5h) and a colour base (3D4h/3D5h). While one base is active, accesses at the other base are ignored.

Most registers cannot be read back. Only the start address and cursor location bytes return their stored values. Indices 10h and 11h have different meanings for reads and for writes. A write stores vertical retrace start or end. A read returns the high or low byte of a display address captured when the light-pen strobe rises.

A 16-bit write to the address port acts as two byte writes. The low byte is written to the address port first, and the high byte then goes to the data port. This lets one bus cycle select a register and load it.

Top module: `crtc_host_regs`

## Requirements
- R1: After reset, every register byte on `regs_o`, `misc_o`, the index latch and the captured light-pen address are zero, so the monochrome base (3B4h/3B5h) is active.
- R2: A byte write to 3C2h stores the byte on `misc_o`. Bit 0 = 1 selects the colour base 3Dx and 0 selects the monochrome base 3Bx. Bits 7..1 are passed on unchanged: bit 7 V-sync negative, bit 6 H-sync negative, bit 5 page, bit 4 drivers off, bits 3:2 clock (00 14 MHz, 01 16 MHz, 10 external), bit 1 RAM enable.
- R3: A byte write to the active address port (base+4) loads the index. A byte write to the active data port (base+5) stores the low data byte into register `idx`, which appears on `regs_o[8*idx +: 8]` after the next clock.
- R4: A data-port write while the index is above 18h leaves all registers unchanged.
- R5: While one base is active, writes to the other base's address or data port change neither the index nor any register, and reads there return FFh.
- R6: A 16-bit write (`io_wide`=1) to the active address port loads the index from `io_wdata[7:0]` and stores `io_wdata[15:8]` into the register at that new index in the same cycle.
- R7: A write to index 11h keeps only data bits 3:0; bits 7:4 of that register read as zero on `regs_o`. A write to index 10h keeps all eight bits.
- R8: A read of the active data port with index 0Ch, 0Dh, 0Eh or 0Fh returns the stored byte.
- R9: A read of the active data port with index 10h returns bits 15:8 of the captured light-pen address, and with index 11h returns bits 7:0.
- R10: A read of the active data port at any other index, or a read of the address port, returns FFh.
- R11: A rising edge on `lpen_strobe_i`, after `LPEN_SYNC` synchronizer stages, captures `scan_addr_i`. Holding the strobe high captures nothing further.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 16 | Write data; the upper byte is used only by 16-bit writes |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wide | input | 1 | Qualifies `io_wr` as a 16-bit write |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, combinational; FFh when nothing drives it |
| scan_addr_i | input | 16 | Current display memory address from the timing generator |
| lpen_strobe_i | input | 1 | Asynchronous light-pen trigger |
| regs_o | output | 200 | All timing registers; byte i holds index i |
| misc_o | output | 8 | Miscellaneous output byte |

## Verification
Assertions run on every cycle and check four things:
- an out-of-range data write leaves the register bus frozen;
- accesses to the inactive base leave the index and the registers untouched;
- the retrace-end mask and the 16-bit index load are applied;
- the captured light-pen address moves only after a synchronized rising edge.

Other behaviour shows only in the bench's sweeps. These include the read mapping, where indices 10h and 11h read differently from how they are written, and the FFh returned at write-only indices. They also include the base swap after a write to 3C2h and the exact values held by all twenty-five registers.

// File: rtl/crtc_regs_pkg.sv
package crtc_regs_pkg;

   localparam logic [7:0] IDX_START_HI  = 8'h0C;
   localparam logic [7:0] IDX_START_LO  = 8'h0D;
   localparam logic [7:0] IDX_CURSOR_HI = 8'h0E;
   localparam logic [7:0] IDX_CURSOR_LO = 8'h0F;
   localparam logic [7:0] IDX_VRS_LPHI  = 8'h10;
   localparam logic [7:0] IDX_VRE_LPLO  = 8'h11;

   localparam logic [7:0] BUS_IDLE = 8'hFF;

   typedef enum logic [1:0] {
      SRC_NONE,
      SRC_STORED,
      SRC_LPEN_HI,
      SRC_LPEN_LO
   } rd_src_e;

   function automatic logic [7:0] write_mask(input int idx);
      return (idx == int'(IDX_VRE_LPLO)) ? 8'h0F : 8'hFF;
   endfunction

   function automatic rd_src_e read_source(input logic [7:0] idx);
      rd_src_e s;
      case (idx)
         IDX_START_HI, IDX_START_LO,
         IDX_CURSOR_HI, IDX_CURSOR_LO: s = SRC_STORED;
         IDX_VRS_LPHI:                 s = SRC_LPEN_HI;
         IDX_VRE_LPLO:                 s = SRC_LPEN_LO;
         default:                      s = SRC_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/crtc_port_decode.sv
module crtc_port_decode #(
   parameter int            AW         = 16,
   parameter logic [AW-1:0] MONO_BASE  = 16'h03B0,
   parameter logic [AW-1:0] COLOR_BASE = 16'h03D0,
   parameter logic [AW-1:0] MISC_ADDR  = 16'h03C2,
   parameter int            IDX_OFF    = 4
) (
   input  logic [AW-1:0] addr,
   input  logic          wr,
   input  logic          wide,
   input  logic          rd,
   input  logic          color_sel,
   output logic          idx_we,
   output logic          dat_lo_we,
   output logic          dat_hi_we,
   output logic          misc_we,
   output logic          dat_rd,
   output logic          idx_rd
);

   localparam logic [AW-1:0] MONO_IDX  = MONO_BASE  + AW'(IDX_OFF);
   localparam logic [AW-1:0] MONO_DAT  = MONO_BASE  + AW'(IDX_OFF + 1);
   localparam logic [AW-1:0] COLOR_IDX = COLOR_BASE + AW'(IDX_OFF);
   localparam logic [AW-1:0] COLOR_DAT = COLOR_BASE + AW'(IDX_OFF + 1);

   if (IDX_OFF % 2 != 0) begin : g_chk_even
      $error("crtc_port_decode: address port must be at an even offset");
   end
   if (MONO_BASE == COLOR_BASE) begin : g_chk_bases
      $error("crtc_port_decode: the two bases must differ");
   end

   logic [AW-1:0] act_idx;
   logic [AW-1:0] act_dat;
   logic          hit_idx;
   logic          hit_dat;

   always_comb begin
      act_idx = color_sel ? COLOR_IDX : MONO_IDX;
      act_dat = color_sel ? COLOR_DAT : MONO_DAT;
      hit_idx = (addr == act_idx);
      hit_dat = (addr == act_dat);
   end

   assign idx_we    = wr & hit_idx;
   assign dat_lo_we = wr & hit_dat;
   assign dat_hi_we = wr & wide & hit_idx;
   assign misc_we   = wr & (addr == MISC_ADDR);
   assign dat_rd    = rd & hit_dat;
   assign idx_rd    = rd & hit_idx;

endmodule

// File: rtl/crtc_reg_bank.sv
module crtc_reg_bank #(
   parameter int NUM_REGS = 25
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  idx_we,
   input  logic [7:0]            idx_wdata,
   input  logic                  dat_we,
   input  logic [7:0]            dat_idx,
   input  logic [7:0]            dat_wdata,
   input  logic                  misc_we,
   input  logic [7:0]            misc_wdata,
   output logic [7:0]            idx_q,
   output logic [7:0]            misc_q,
   output logic [NUM_REGS*8-1:0] regs_o
);

   localparam logic [7:0] LAST_IDX = 8'(NUM_REGS - 1);

   if (NUM_REGS < 18 || NUM_REGS > 256) begin : g_chk_count
      $error("crtc_reg_bank: NUM_REGS out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_we) idx_q <= idx_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       misc_q <= '0;
      else if (misc_we) misc_q <= misc_wdata;
   end

   for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
      localparam logic [7:0] MASK = crtc_regs_pkg::write_mask(gi);
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               q <= '0;
         else if (dat_we && dat_idx == 8'(gi))     q <= dat_wdata & MASK;
      end
      assign regs_o[gi*8 +: 8] = q;
   end

   a_r4_out_of_range_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && dat_idx > LAST_IDX) |=> $stable(regs_o));

   a_r7_retrace_end_masked : assert property (@(posedge clk) disable iff (!rst_n)
      (dat_we && dat_idx == crtc_regs_pkg::IDX_VRE_LPLO)
      |=> regs_o[8*17 +: 8] == {4'h0, $past(dat_wdata[3:0])});

   a_r2_misc_stored : assert property (@(posedge clk) disable iff (!rst_n)
      misc_we |=> misc_q == $past(misc_wdata));

endmodule

// File: rtl/crtc_lpen_latch.sv
module crtc_lpen_latch #(
   parameter int MA_W      = 16,
   parameter int SYNC_DEPTH = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            strobe_i,
   input  logic [MA_W-1:0] scan_addr_i,
   output logic [MA_W-1:0] lpen_q
);

   logic strobe_s;
   logic strobe_prev;
   logic rise;

   if (SYNC_DEPTH == 0) begin : g_nosync
      assign strobe_s = strobe_i;
   end else begin : g_sync
      logic [SYNC_DEPTH-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_DEPTH-2:0], strobe_i};
      end
      assign strobe_s = chain[SYNC_DEPTH-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_prev <= 1'b0;
      else        strobe_prev <= strobe_s;
   end

   assign rise = strobe_s & ~strobe_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lpen_q <= '0;
      else if (rise) lpen_q <= scan_addr_i;
   end

   a_r11_capture_only_on_edge : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lpen_q) |-> $past(strobe_s) && !$past(strobe_prev));

   a_r11_held_strobe_no_recapture : assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_s && strobe_prev) |=> $stable(lpen_q));

endmodule

// File: rtl/crtc_host_regs.sv
module crtc_host_regs #(
   parameter int            AW         = 16,
   parameter int            NUM_REGS   = 25,
   parameter int            MA_W       = 16,
   parameter int            LPEN_SYNC  = 2,
   parameter logic [AW-1:0] MONO_BASE  = 16'h03B0,
   parameter logic [AW-1:0] COLOR_BASE = 16'h03D0,
   parameter logic [AW-1:0] MISC_ADDR  = 16'h03C2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [AW-1:0]         io_addr,
   input  logic [15:0]           io_wdata,
   input  logic                  io_wr,
   input  logic                  io_wide,
   input  logic                  io_rd,
   output logic [7:0]            io_rdata,
   input  logic [MA_W-1:0]       scan_addr_i,
   input  logic                  lpen_strobe_i,
   output logic [NUM_REGS*8-1:0] regs_o,
   output logic [7:0]            misc_o
);
   import crtc_regs_pkg::*;

   localparam int IDX_OFF = 4;

   if (MA_W < 9 || MA_W > 16) begin : g_chk_ma
      $error("crtc_host_regs: MA_W must lie in 9..16");
   end
   if (LPEN_SYNC < 0 || LPEN_SYNC == 1) begin : g_chk_sync
      $error("crtc_host_regs: LPEN_SYNC must be 0 or at least 2");
   end

   logic idx_we, dat_lo_we, dat_hi_we, misc_we, dat_rd, idx_rd;
   logic [7:0] idx_q;
   logic [MA_W-1:0] lpen_q;

   crtc_port_decode #(
      .AW(AW), .MONO_BASE(MONO_BASE), .COLOR_BASE(COLOR_BASE),
      .MISC_ADDR(MISC_ADDR), .IDX_OFF(IDX_OFF)
   ) u_decode (
      .addr(io_addr), .wr(io_wr), .wide(io_wide), .rd(io_rd),
      .color_sel(misc_o[0]),
      .idx_we(idx_we), .dat_lo_we(dat_lo_we), .dat_hi_we(dat_hi_we),
      .misc_we(misc_we), .dat_rd(dat_rd), .idx_rd(idx_rd)
   );

   logic       dat_we;
   logic [7:0] dat_idx;
   logic [7:0] dat_val;

   always_comb begin
      dat_we  = dat_lo_we | dat_hi_we;
      dat_idx = dat_hi_we ? io_wdata[7:0]  : idx_q;
      dat_val = dat_hi_we ? io_wdata[15:8] : io_wdata[7:0];
   end

   crtc_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .idx_we(idx_we), .idx_wdata(io_wdata[7:0]),
      .dat_we(dat_we), .dat_idx(dat_idx), .dat_wdata(dat_val),
      .misc_we(misc_we), .misc_wdata(io_wdata[7:0]),
      .idx_q(idx_q), .misc_q(misc_o), .regs_o(regs_o)
   );

   crtc_lpen_latch #(.MA_W(MA_W), .SYNC_DEPTH(LPEN_SYNC)) u_lpen (
      .clk(clk), .rst_n(rst_n),
      .strobe_i(lpen_strobe_i), .scan_addr_i(scan_addr_i),
      .lpen_q(lpen_q)
   );

   logic [15:0] lpen_ext;
   logic [7:0]  stored_byte;
   rd_src_e     src;

   assign lpen_ext = 16'(lpen_q);

   always_comb begin
      stored_byte = BUS_IDLE;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (idx_q == 8'(k)) stored_byte = regs_o[k*8 +: 8];
      end
   end

   always_comb begin
      src = read_source(idx_q);
      io_rdata = BUS_IDLE;
      if (dat_rd) begin
         case (src)
            SRC_STORED:  io_rdata = stored_byte;
            SRC_LPEN_HI: io_rdata = lpen_ext[15:8];
            SRC_LPEN_LO: io_rdata = lpen_ext[7:0];
            default:     io_rdata = BUS_IDLE;
         endcase
      end
   end

   logic [AW-1:0] other_idx;
   logic [AW-1:0] act_idx;
   assign other_idx = (misc_o[0] ? MONO_BASE : COLOR_BASE) + AW'(IDX_OFF);
   assign act_idx   = (misc_o[0] ? COLOR_BASE : MONO_BASE) + AW'(IDX_OFF);

   a_r5_inactive_base_ignored : assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && (io_addr == other_idx || io_addr == other_idx + AW'(1)))
      |=> $stable(regs_o) && $stable(idx_q));

   a_r6_wide_loads_index : assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_wide && io_addr == act_idx) |=> idx_q == $past(io_wdata[7:0]));

   a_r3_narrow_single_target : assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && !io_wide) |-> $onehot0({idx_we, dat_lo_we, misc_we}));

   a_r10_idx_port_undriven : assert property (@(posedge clk) disable iff (!rst_n)
      idx_rd |-> io_rdata == BUS_IDLE);

endmodule

// File: tb/crtc_host_regs_bench.sv
module crtc_host_regs_bench;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [15:0]  io_addr = '0;
   logic [15:0]  io_wdata = '0;
   logic         io_wr = 1'b0;
   logic         io_wide = 1'b0;
   logic         io_rd = 1'b0;
   logic [7:0]   io_rdata;
   logic [15:0]  scan_addr = '0;
   logic         lpen = 1'b0;
   logic [199:0] regs;
   logic [7:0]   misc;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0]  exp_regs [25];
   logic [15:0] exp_lpen = '0;

   always #4 clk = ~clk;

   crtc_host_regs u_crtc_host_regs (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
      .io_wr(io_wr), .io_wide(io_wide), .io_rd(io_rd), .io_rdata(io_rdata),
      .scan_addr_i(scan_addr), .lpen_strobe_i(lpen),
      .regs_o(regs), .misc_o(misc)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr8(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = {8'h00, d}; io_wr = 1'b1; io_wide = 1'b0;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic wr16(input logic [15:0] a, input logic [15:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1; io_wide = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_wide = 1'b0;
   endtask

   task automatic rd8(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      #1 d = io_rdata;
      io_rd = 1'b0;
   endtask

   task automatic chk_regs(input string req);
      for (int i = 0; i < 25; i++) chk(req, regs[i*8 +: 8], exp_regs[i]);
   endtask

   function automatic logic [7:0] exp_read(input int idx);
      if (idx >= 12 && idx <= 15) return exp_regs[idx];
      if (idx == 16) return exp_lpen[15:8];
      if (idx == 17) return exp_lpen[7:0];
      return 8'hFF;
   endfunction

   function automatic logic [7:0] store_val(input int idx, input logic [7:0] d);
      return (idx == 17) ? {4'h0, d[3:0]} : d;
   endfunction

   initial begin
      logic [7:0] rv;
      logic [15:0] ib, ob;
      for (int i = 0; i < 25; i++) exp_regs[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_regs("R1");
      chk("R1", misc, 8'h00);
      wr8(16'h03B4, 8'h0C);
      rd8(16'h03B5, rv); chk("R1", rv, 8'h00);
      wr8(16'h03B4, 8'h10);
      rd8(16'h03B5, rv); chk("R1", rv, 8'h00);

      // R3 R7 fill every register through the monochrome pair
      for (int i = 0; i < 25; i++) begin
         logic [7:0] v;
         v = 8'((i * 37 + 11) ^ 8'hA0);
         wr8(16'h03B4, 8'(i));
         wr8(16'h03B5, v);
         exp_regs[i] = store_val(i, v);
      end
      chk_regs("R3");
      chk("R7", regs[17*8 +: 8], 8'h0F & 8'((17 * 37 + 11) ^ 8'hA0));
      chk("R7", regs[16*8 +: 8], 8'((16 * 37 + 11) ^ 8'hA0));

      // R8 R9 R10 read sweep
      for (int i = 0; i < 32; i++) begin
         wr8(16'h03B4, 8'(i));
         rd8(16'h03B5, rv);
         if (i >= 12 && i <= 15)      chk("R8", rv, exp_read(i));
         else if (i == 16 || i == 17) chk("R9", rv, exp_read(i));
         else                         chk("R10", rv, exp_read(i));
      end
      rd8(16'h03B4, rv); chk("R10", rv, 8'hFF);

      // R4 out-of-range index writes
      for (int j = 25; j < 256; j++) begin
         wr8(16'h03B4, 8'(j));
         wr8(16'h03B5, ~8'(j));
         chk_regs("R4");
      end

      // R5 colour pair ignored while monochrome
      wr8(16'h03B4, 8'h0C);
      wr8(16'h03D4, 8'h0D);
      wr8(16'h03D5, 8'h5C);
      chk_regs("R5");
      rd8(16'h03B5, rv); chk("R5", rv, exp_regs[12]);
      rd8(16'h03D5, rv); chk("R5", rv, 8'hFF);

      // R2 switch to colour base
      wr8(16'h03C2, 8'hC5);
      chk("R2", misc, 8'hC5);
      wr8(16'h03D4, 8'h0E);
      wr8(16'h03D5, 8'h77); exp_regs[14] = 8'h77;
      chk_regs("R2");
      wr8(16'h03B4, 8'h0D);
      wr8(16'h03B5, 8'h99);
      chk_regs("R5");
      rd8(16'h03D5, rv); chk("R5", rv, 8'h77);
      rd8(16'h03B5, rv); chk("R5", rv, 8'hFF);
      wr8(16'h03C2, 8'h3A);
      chk("R2", misc, 8'h3A);
      wr8(16'h03B4, 8'h0F);
      wr8(16'h03B5, 8'h42); exp_regs[15] = 8'h42;
      chk_regs("R2");
      wr8(16'h03C2, 8'h01);
      chk("R2", misc, 8'h01);

      // R6 16-bit writes at the colour address port
      for (int i = 0; i < 25; i++) begin
         logic [7:0] v;
         v = 8'(255 - i * 9);
         wr16(16'h03D4, {v, 8'(i)});
         exp_regs[i] = store_val(i, v);
      end
      chk_regs("R6");
      wr16(16'h03D4, 16'hF311); exp_regs[17] = 8'h03;
      chk("R7", regs[17*8 +: 8], 8'h03);
      wr16(16'h03D4, 16'h5A0E); exp_regs[14] = 8'h5A;
      rd8(16'h03D5, rv); chk("R6", rv, 8'h5A);
      wr16(16'h03D4, 16'h6640);
      chk_regs("R6");

      // R11 light-pen capture
      @(negedge clk);
      scan_addr = 16'h1234; lpen = 1'b1;
      repeat (5) @(negedge clk);
      scan_addr = 16'hBEEF;
      repeat (5) @(negedge clk);
      exp_lpen = 16'h1234;
      wr8(16'h03D4, 8'h10); rd8(16'h03D5, rv); chk("R11", rv, 8'h12);
      wr8(16'h03D4, 8'h11); rd8(16'h03D5, rv); chk("R9", rv, 8'h34);
      lpen = 1'b0;
      repeat (4) @(negedge clk);
      scan_addr = 16'h9ABC; lpen = 1'b1;
      repeat (5) @(negedge clk);
      scan_addr = 16'h0000;
      exp_lpen = 16'h9ABC;
      wr8(16'h03D4, 8'h10); rd8(16'h03D5, rv); chk("R11", rv, 8'h9A);
      wr8(16'h03D4, 8'h11); rd8(16'h03D5, rv); chk("R11", rv, 8'hBC);
      chk_regs("R11");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule